// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block chooses, each clock cycle, which ready instructions leave the issue window. Five ready pools feed it: integer, floating point, branch, memory and miscellaneous. Each pool shows a short view of its oldest ready entries. For each entry the view gives a 16-bit sequence number and a squash flag, and the pool also gives a count of how many of its entries are valid. Pools list their entries oldest first, so entry 0 is the pool head.

The selection runs as a fixed chain of picks. At each pick, every pool that is still allowed to issue drops any squashed entries at its head. The selector then issues the head with the smallest sequence number. The chain stops when the total issue width is reached or when no allowed pool has a candidate. The integer, floating-point, branch and memory pools each have their own cap on issues per cycle. The miscellaneous pool is bounded only by the total width.

The result is registered. It gives the issue bundle, the bundle size (which is also the number of window entries freed), the number of instructions issued from each class, and the number of entries each pool must pop. The pop count covers both issued entries and discarded squashed entries.

Top module: `iq_oldest_issue_sel`

## Requirements
- R1: No more than ISSUE_W (default 4) instructions issue in one cycle.
- R2: At most INT_CAP=2 integer, FP_CAP=1 floating-point, BR_CAP=1 branch and MEM_CAP=2 memory instructions issue per cycle. Once a pool reaches its cap, it is not examined again that cycle, so squashed entries behind its last issue stay in place and are not counted in its pop count.
- R3: The miscellaneous pool (class code 4) has no cap of its own. It can fill the whole bundle.
- R4: Each pick takes the eligible head with the smallest unsigned 16-bit sequence number. When two heads have equal numbers, the pool with the lower class code wins.
- R5: A squashed head of an eligible pool is discarded and not issued. It adds one to that pool's pop count and uses no issue width.
- R6: Issued instructions fill bundle slots in order from slot 0. bundle_vld has exactly bundle_size low bits set. Each slot carries its sequence number and class code (0 integer, 1 floating point, 2 branch, 3 memory, 4 miscellaneous).
- R7: cls_issued gives the count issued from each class. The sum of these counts equals bundle_size, which is the number of window entries freed.
- R8: Selection stops when no eligible pool has a candidate or when the total width is reached. A squashed entry that becomes a pool head only after the final issue is not discarded.
- R9: Outputs change on the clock edge after the inputs are sampled. A synchronous active-high reset clears every output to zero.
- R10: Entries at positions at or above a pool's count are ignored, whatever their sequence number or squash flag. A count above DEPTH is treated as DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pool_cnt | input | 5 x 3 | Number of valid entries shown by each pool |
| pool_seq | input | 5 x DEPTH x 16 | Sequence number of each shown entry, oldest at index 0 |
| pool_sq | input | 5 x DEPTH | Squash flag of each shown entry |
| bundle_vld | output | ISSUE_W | Slot holds an issued instruction |
| bundle_seq | output | ISSUE_W x 16 | Sequence number in each slot |
| bundle_cls | output | ISSUE_W x 3 | Class code in each slot |
| bundle_size | output | 3 | Number of instructions issued, equal to the entries freed |
| cls_issued | output | 5 x 3 | Instructions issued from each class |
| pool_pop | output | 5 x 3 | Entries to remove from each pool (issued plus discarded) |

## Verification
Discarding a squashed head and issuing from another pool can happen in the same cycle, as can a pool hitting its cap while other pools keep issuing. Table vectors mix squash masks and interleaved sequence numbers across all pools to provoke these cases. Each vector is judged against an iterative reference model in the bench, which restarts its scan after every discard. Directed cases cover the remaining interactions: a squashed entry exposed just as the width fills, a squashed entry behind a capped pool, and sequence-number ties between pools. These cases are judged on the pop counts and the slot order.

// File: rtl/iq_sel_pkg.sv
package iq_sel_pkg;
    localparam int NPOOL = 5;
    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_INT  = 3'd0,
        CLS_FP   = 3'd1,
        CLS_BR   = 3'd2,
        CLS_MEM  = 3'd3,
        CLS_MISC = 3'd4
    } cls_e;

    // bits needed to hold a count from 0 to n
    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/iq_head_scan.sv
module iq_head_scan #(
    parameter int DEPTH = 4,
    parameter int PTR_W = 3
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] cnt,
    input  logic [DEPTH-1:0] sq,
    output logic [PTR_W-1:0] first,
    output logic             found
);
    logic [PTR_W-1:0] lim;

    always_comb begin
        lim = (cnt > PTR_W'(DEPTH)) ? PTR_W'(DEPTH) : cnt;
        first = lim;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (PTR_W'(i) >= ptr && PTR_W'(i) < lim && !sq[i])
                first = PTR_W'(i);
        end
        found = (first < lim);
    end
endmodule

// File: rtl/iq_oldest_pick.sv
module iq_oldest_pick
    import iq_sel_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic [NPOOL-1:0]            cand,
    input  logic [NPOOL-1:0][SEQ_W-1:0] seq,
    output logic                        any,
    output logic [CLS_W-1:0]            win,
    output logic [SEQ_W-1:0]            win_seq
);
    always_comb begin
        any     = 1'b0;
        win     = '0;
        win_seq = '0;
        for (int p = 0; p < NPOOL; p++) begin
            // strict compare keeps the lower class code on a tie
            if (cand[p] && (!any || seq[p] < win_seq)) begin
                any     = 1'b1;
                win     = CLS_W'(p);
                win_seq = seq[p];
            end
        end
    end
endmodule

// File: rtl/iq_pick_stage.sv
module iq_pick_stage
    import iq_sel_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SEQ_W = 16,
    parameter int PTR_W = 3,
    parameter int CNT_W = 3
) (
    input  logic                                  active_in,
    input  logic [NPOOL-1:0][CNT_W-1:0]           cap,
    input  logic [NPOOL-1:0][PTR_W-1:0]           cnt,
    input  logic [NPOOL-1:0][DEPTH-1:0]           sq,
    input  logic [NPOOL-1:0][DEPTH-1:0][SEQ_W-1:0] seq,
    input  logic [NPOOL-1:0][PTR_W-1:0]           ptr_in,
    input  logic [NPOOL-1:0][CNT_W-1:0]           used_in,
    output logic [NPOOL-1:0][PTR_W-1:0]           ptr_out,
    output logic [NPOOL-1:0][CNT_W-1:0]           used_out,
    output logic                                  pick_vld,
    output logic [CLS_W-1:0]                      pick_cls,
    output logic [SEQ_W-1:0]                      pick_seq,
    output logic                                  active_out
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [NPOOL-1:0]            allowed;
    logic [NPOOL-1:0]            found;
    logic [NPOOL-1:0]            cand;
    logic [NPOOL-1:0][PTR_W-1:0] first;
    logic [NPOOL-1:0][PTR_W-1:0] mid_ptr;
    logic [NPOOL-1:0][SEQ_W-1:0] head_seq;
    logic                        any;
    logic [CLS_W-1:0]            win;
    logic [SEQ_W-1:0]            win_seq;

    for (genvar p = 0; p < NPOOL; p++) begin : g_pool
        iq_head_scan #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_scan (
            .ptr   (ptr_in[p]),
            .cnt   (cnt[p]),
            .sq    (sq[p]),
            .first (first[p]),
            .found (found[p])
        );
        assign allowed[p]  = active_in && (used_in[p] < cap[p]);
        assign cand[p]     = allowed[p] && found[p];
        assign head_seq[p] = found[p] ? seq[p][first[p][IDX_W-1:0]] : '0;
        // an eligible pool drops its squashed head entries
        assign mid_ptr[p]  = allowed[p] ? first[p] : ptr_in[p];
    end

    iq_oldest_pick #(.SEQ_W(SEQ_W)) u_pick (
        .cand    (cand),
        .seq     (head_seq),
        .any     (any),
        .win     (win),
        .win_seq (win_seq)
    );

    always_comb begin
        ptr_out  = mid_ptr;
        used_out = used_in;
        if (any) begin
            ptr_out[win]  = first[win] + PTR_W'(1);
            used_out[win] = used_in[win] + CNT_W'(1);
        end
    end

    assign pick_vld   = any;
    assign pick_cls   = win;
    assign pick_seq   = win_seq;
    assign active_out = active_in && any;
endmodule

// File: rtl/iq_oldest_issue_sel.sv
module iq_oldest_issue_sel
    import iq_sel_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int DEPTH   = 4,
    parameter int SEQ_W   = 16,
    parameter int INT_CAP = 2,
    parameter int FP_CAP  = 1,
    parameter int BR_CAP  = 1,
    parameter int MEM_CAP = 2
) (
    input  logic                                               clk,
    input  logic                                               rst,
    input  logic [NPOOL-1:0][$clog2(DEPTH+1)-1:0]              pool_cnt,
    input  logic [NPOOL-1:0][DEPTH-1:0][SEQ_W-1:0]             pool_seq,
    input  logic [NPOOL-1:0][DEPTH-1:0]                        pool_sq,
    output logic [ISSUE_W-1:0]                                 bundle_vld,
    output logic [ISSUE_W-1:0][SEQ_W-1:0]                      bundle_seq,
    output logic [ISSUE_W-1:0][CLS_W-1:0]                      bundle_cls,
    output logic [$clog2(ISSUE_W+1)-1:0]                       bundle_size,
    output logic [NPOOL-1:0][$clog2(ISSUE_W+1)-1:0]            cls_issued,
    output logic [NPOOL-1:0][$clog2(DEPTH+1)-1:0]              pool_pop
);
    localparam int PTR_W = cnt_bits(DEPTH);
    localparam int CNT_W = cnt_bits(ISSUE_W);

    logic [NPOOL-1:0][CNT_W-1:0] cap_v;
    assign cap_v[CLS_INT]  = CNT_W'(INT_CAP);
    assign cap_v[CLS_FP]   = CNT_W'(FP_CAP);
    assign cap_v[CLS_BR]   = CNT_W'(BR_CAP);
    assign cap_v[CLS_MEM]  = CNT_W'(MEM_CAP);
    assign cap_v[CLS_MISC] = CNT_W'(ISSUE_W);

    logic [NPOOL-1:0][PTR_W-1:0] ptr_c  [ISSUE_W+1];
    logic [NPOOL-1:0][CNT_W-1:0] used_c [ISSUE_W+1];
    logic                        act_c  [ISSUE_W+1];
    logic                        pk_vld [ISSUE_W];
    logic [CLS_W-1:0]            pk_cls [ISSUE_W];
    logic [SEQ_W-1:0]            pk_seq [ISSUE_W];

    assign ptr_c[0]  = '0;
    assign used_c[0] = '0;
    assign act_c[0]  = 1'b1;

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_stage
        iq_pick_stage #(
            .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
        ) u_stage (
            .active_in  (act_c[k]),
            .cap        (cap_v),
            .cnt        (pool_cnt),
            .sq         (pool_sq),
            .seq        (pool_seq),
            .ptr_in     (ptr_c[k]),
            .used_in    (used_c[k]),
            .ptr_out    (ptr_c[k+1]),
            .used_out   (used_c[k+1]),
            .pick_vld   (pk_vld[k]),
            .pick_cls   (pk_cls[k]),
            .pick_seq   (pk_seq[k]),
            .active_out (act_c[k+1])
        );
    end

    logic [ISSUE_W-1:0]            vld_nxt;
    logic [ISSUE_W-1:0][SEQ_W-1:0] seq_nxt;
    logic [ISSUE_W-1:0][CLS_W-1:0] cls_nxt;
    logic [CNT_W-1:0]              size_nxt;

    always_comb begin
        size_nxt = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            vld_nxt[k] = pk_vld[k];
            seq_nxt[k] = pk_vld[k] ? pk_seq[k] : '0;
            cls_nxt[k] = pk_vld[k] ? pk_cls[k] : '0;
            if (pk_vld[k]) size_nxt = size_nxt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bundle_vld  <= '0;
            bundle_seq  <= '0;
            bundle_cls  <= '0;
            bundle_size <= '0;
            cls_issued  <= '0;
            pool_pop    <= '0;
        end else begin
            bundle_vld  <= vld_nxt;
            bundle_seq  <= seq_nxt;
            bundle_cls  <= cls_nxt;
            bundle_size <= size_nxt;
            cls_issued  <= used_c[ISSUE_W];
            pool_pop    <= ptr_c[ISSUE_W];
        end
    end

    logic [CNT_W+2:0] issued_sum;
    always_comb begin
        issued_sum = '0;
        for (int p = 0; p < NPOOL; p++)
            issued_sum = issued_sum + (CNT_W+3)'(cls_issued[p]);
    end

    assert_width_R1: assert property (@(posedge clk) disable iff (rst)
        bundle_size <= CNT_W'(ISSUE_W));

    for (genvar p = 0; p < NPOOL - 1; p++) begin : g_cap_chk
        assert_cap_R2: assert property (@(posedge clk) disable iff (rst)
            cls_issued[p] <= cap_v[p]);
    end

    for (genvar p = 0; p < NPOOL; p++) begin : g_pop_chk
        assert_pop_R5: assert property (@(posedge clk) disable iff (rst)
            PTR_W'(cls_issued[p]) <= pool_pop[p]);
    end

    assert_slots_R6: assert property (@(posedge clk) disable iff (rst)
        ($countones(bundle_vld) == int'(bundle_size)) &&
        ((bundle_vld & (bundle_vld + ISSUE_W'(1))) == '0));

    assert_sum_R7: assert property (@(posedge clk) disable iff (rst)
        issued_sum == (CNT_W+3)'(bundle_size));

    assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bundle_size == '0 && bundle_vld == '0));
endmodule

// File: tb/iq_oldest_issue_sel_tb.sv
module iq_oldest_issue_sel_tb;
    localparam int W = 4;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0][2:0]         pool_cnt;
    logic [4:0][D-1:0][15:0] pool_seq;
    logic [4:0][D-1:0]       pool_sq;
    logic [W-1:0]            bundle_vld;
    logic [W-1:0][15:0]      bundle_seq;
    logic [W-1:0][2:0]       bundle_cls;
    logic [2:0]              bundle_size;
    logic [4:0][2:0]         cls_issued;
    logic [4:0][2:0]         pool_pop;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    iq_oldest_issue_sel u_dut (
        .clk(clk), .rst(rst), .pool_cnt(pool_cnt), .pool_seq(pool_seq),
        .pool_sq(pool_sq), .bundle_vld(bundle_vld), .bundle_seq(bundle_seq),
        .bundle_cls(bundle_cls), .bundle_size(bundle_size),
        .cls_issued(cls_issued), .pool_pop(pool_pop)
    );

    typedef struct packed {
        logic [4:0][2:0]  cnt;
        logic [4:0][15:0] base;
        logic [4:0][3:0]  sq;
    } vec_t;

    // field order inside each concatenation: misc, mem, br, fp, int
    localparam vec_t VECS [8] = '{
        '{cnt: {3'd0,3'd0,3'd0,3'd0,3'd0}, base: {16'd0,16'd0,16'd0,16'd0,16'd0},
          sq: {4'h0,4'h0,4'h0,4'h0,4'h0}},
        '{cnt: {3'd1,3'd2,3'd1,3'd2,3'd4}, base: {16'd40,16'd10,16'd3,16'd7,16'd1},
          sq: {4'h0,4'h0,4'h0,4'h0,4'h0}},
        '{cnt: {3'd4,3'd4,3'd4,3'd4,3'd4}, base: {16'd4,16'd3,16'd2,16'd1,16'd0},
          sq: {4'h0,4'h0,4'h0,4'h0,4'h0}},
        '{cnt: {3'd2,3'd3,3'd2,3'd3,3'd3}, base: {16'd0,16'd2,16'd4,16'd6,16'd8},
          sq: {4'h1,4'h3,4'h0,4'h5,4'h2}},
        '{cnt: {3'd4,3'd0,3'd0,3'd0,3'd4}, base: {16'd100,16'd0,16'd0,16'd0,16'd200},
          sq: {4'h0,4'h0,4'h0,4'h0,4'hF}},
        '{cnt: {3'd3,3'd3,3'd3,3'd3,3'd3}, base: {16'd9,16'd8,16'd7,16'd6,16'd5},
          sq: {4'h0,4'hF,4'hF,4'hF,4'hF}},
        '{cnt: {3'd7,3'd7,3'd1,3'd1,3'd1}, base: {16'd20,16'd30,16'd1,16'd2,16'd3},
          sq: {4'h0,4'h0,4'h0,4'h0,4'h0}},
        '{cnt: {3'd0,3'd4,3'd0,3'd0,3'd4}, base: {16'd0,16'd65520,16'd0,16'd0,16'd65525},
          sq: {4'h0,4'h0,4'h0,4'h0,4'h0}}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        pool_cnt = '0;
        pool_seq = '0;
        pool_sq  = '0;
    endtask

    task automatic load_vec(input vec_t v);
        for (int p = 0; p < 5; p++) begin
            pool_cnt[p] = v.cnt[p];
            pool_sq[p]  = v.sq[p];
            for (int i = 0; i < D; i++)
                pool_seq[p][i] = v.base[p] + 16'(5 * i);
        end
    endtask

    // iterative model: rescan after every discarded squashed head
    int e_size;
    int e_seq [W];
    int e_cls [W];
    int e_iss [5];
    int e_pop [5];

    task automatic run_model();
        int capv [5];
        int lim [5];
        int best, guard;
        logic [15:0] bseq;
        bit avail, restart;
        capv = '{2, 1, 1, 2, W};
        for (int p = 0; p < 5; p++) begin
            e_iss[p] = 0;
            e_pop[p] = 0;
            lim[p] = (int'(pool_cnt[p]) > D) ? D : int'(pool_cnt[p]);
        end
        for (int k = 0; k < W; k++) begin
            e_seq[k] = 0;
            e_cls[k] = 0;
        end
        e_size = 0;
        avail = 1'b1;
        guard = 0;
        bseq = '0;
        while (avail && e_size < W && guard < 64) begin
            guard++;
            avail = 1'b0;
            restart = 1'b0;
            best = -1;
            for (int p = 0; p < 5; p++) begin
                if (!restart && e_pop[p] < lim[p] && e_iss[p] < capv[p]) begin
                    avail = 1'b1;
                    if (pool_sq[p][e_pop[p]]) begin
                        e_pop[p]++;
                        restart = 1'b1;
                    end else if (best < 0 || pool_seq[p][e_pop[p]] < bseq) begin
                        best = p;
                        bseq = pool_seq[p][e_pop[p]];
                    end
                end
            end
            if (!restart) begin
                if (best < 0) break;
                e_seq[e_size] = int'(bseq);
                e_cls[e_size] = best;
                e_pop[best]++;
                e_iss[best]++;
                e_size++;
            end
        end
    endtask

    // inputs already driven; take the edge and compare with the model
    task automatic step_and_check();
        @(posedge clk);
        #1;
        run_model();
        chk("R1 bundle size", int'(bundle_size), e_size);
        for (int k = 0; k < W; k++) begin
            chk("R6 slot valid", int'(bundle_vld[k]), (k < e_size) ? 1 : 0);
            if (k < e_size) begin
                chk("R4 slot sequence", int'(bundle_seq[k]), e_seq[k]);
                chk("R6 slot class", int'(bundle_cls[k]), e_cls[k]);
            end
        end
        for (int p = 0; p < 5; p++) begin
            chk("R7 class issued", int'(cls_issued[p]), e_iss[p]);
            chk("R5 pool pop", int'(pool_pop[p]), e_pop[p]);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        clear_in();
        load_vec(VECS[1]);
        // R9: reset holds outputs at zero while inputs are live
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset size", int'(bundle_size), 0);
        chk("R9 reset valid", int'(bundle_vld), 0);
        chk("R9 reset pop", int'(pool_pop), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            load_vec(VECS[v]);
            step_and_check();
        end

        // R3: miscellaneous pool alone fills the bundle
        @(negedge clk);
        clear_in();
        pool_cnt[4] = 3'd4;
        for (int i = 0; i < D; i++) pool_seq[4][i] = 16'(10 + i);
        step_and_check();
        chk("R3 misc issued", int'(cls_issued[4]), 4);

        // R2: integer capped at 2; squashed entry behind the cap stays
        @(negedge clk);
        clear_in();
        pool_cnt[0] = 3'd4;
        pool_sq[0]  = 4'b0100;
        for (int i = 0; i < D; i++) pool_seq[0][i] = 16'(1 + i);
        pool_cnt[4] = 3'd4;
        for (int i = 0; i < D; i++) pool_seq[4][i] = 16'(100 + i);
        step_and_check();
        chk("R2 int issued", int'(cls_issued[0]), 2);
        chk("R2 int pop", int'(pool_pop[0]), 2);
        chk("R2 slot2 seq", int'(bundle_seq[2]), 100);

        // R4: equal sequence numbers, lower class code first
        @(negedge clk);
        clear_in();
        pool_cnt[0] = 3'd1; pool_seq[0][0] = 16'd7;
        pool_cnt[1] = 3'd1; pool_seq[1][0] = 16'd7;
        step_and_check();
        chk("R4 tie slot0 class", int'(bundle_cls[0]), 0);
        chk("R4 tie slot1 class", int'(bundle_cls[1]), 1);

        // R8: squashed entry exposed by the final issue is kept
        @(negedge clk);
        clear_in();
        pool_cnt[0] = 3'd2; pool_seq[0][0] = 16'd10; pool_seq[0][1] = 16'd11;
        pool_sq[0]  = 4'b0010;
        pool_cnt[4] = 3'd3;
        for (int i = 0; i < 3; i++) pool_seq[4][i] = 16'(1 + i);
        step_and_check();
        chk("R8 int pop", int'(pool_pop[0]), 1);
        chk("R8 slot3 seq", int'(bundle_seq[3]), 10);

        // R8: nothing ready gives an empty bundle
        @(negedge clk);
        clear_in();
        step_and_check();
        chk("R8 empty size", int'(bundle_size), 0);

        // R5: two squashed heads dropped, width unaffected
        @(negedge clk);
        clear_in();
        pool_cnt[1] = 3'd3; pool_sq[1] = 4'b0011;
        pool_seq[1][0] = 16'd1; pool_seq[1][1] = 16'd2; pool_seq[1][2] = 16'd5;
        pool_cnt[0] = 3'd1; pool_seq[0][0] = 16'd3;
        step_and_check();
        chk("R5 fp pop", int'(pool_pop[1]), 3);
        chk("R5 size", int'(bundle_size), 2);
        chk("R5 slot1 seq", int'(bundle_seq[1]), 5);

        // R10: entries beyond the count are ignored
        @(negedge clk);
        clear_in();
        pool_cnt[0] = 3'd1;
        pool_seq[0][0] = 16'd9; pool_seq[0][1] = 16'd1; pool_seq[0][2] = 16'd2;
        step_and_check();
        chk("R10 size", int'(bundle_size), 1);
        chk("R10 seq", int'(bundle_seq[0]), 9);
        chk("R10 pop", int'(pool_pop[0]), 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule